// File: doc/BRIEF.md
# Nibble-to-Byte Handshake Bridge

The bridge sits between a narrow sender and a wider receiver. The sender presents a 4-bit value on `nib_in` and raises `nib_stb` to qualify it. The bridge collects two such values and joins them into one byte. The value taken first fills the lower half of the byte and the value taken second fills the upper half. The byte is then put on `word_out`, and `word_stb` is raised for a single clock to announce it.

A controller built as a state machine drives a small datapath, and the state machine walks through eight named states:

- `ST_WAIT_LO` waits for a strobe.
- `ST_TAKE_LO` loads the lower half.
- `ST_HOLD_LO` waits for the strobe to drop.
- `ST_WAIT_HI`, `ST_TAKE_HI` and `ST_HOLD_HI` do the same for the upper half.
- `ST_EMIT` loads the output register.
- `ST_EMIT_END` is the cycle in which the output strobe is seen. After it the machine goes back to `ST_WAIT_LO`.

Every capture is edge-qualified: a strobe is taken once, and the next one is accepted only after the strobe has been seen low. The transitions are listed below:

| From | Condition | To |
|------|-----------|----|
| `ST_WAIT_LO` | strobe high | `ST_TAKE_LO` |
| `ST_TAKE_LO` | strobe high / low | `ST_HOLD_LO` / `ST_WAIT_HI` |
| `ST_HOLD_LO` | strobe low | `ST_WAIT_HI` |
| `ST_WAIT_HI` | strobe high | `ST_TAKE_HI` |
| `ST_TAKE_HI` | strobe high / low | `ST_HOLD_HI` / `ST_EMIT` |
| `ST_HOLD_HI` | strobe low | `ST_EMIT` |
| `ST_EMIT` | always | `ST_EMIT_END` |
| `ST_EMIT_END` | always | `ST_WAIT_LO` |
| any other code | always | `ST_WAIT_LO` |

`nib_in` is registered on every clock. A nibble is therefore taken from the value present on the clock edge at which the bridge first sees the strobe high. A one-cycle strobe is enough.

Top module: `nibble_pair_bridge`

## Requirements
- R1: A synchronous reset (`rst` high, held at least two clocks) leaves `word_out` at 0 and `word_stb` at 0.
- R2: The byte presented is `{second nibble, first nibble}`: the first nibble taken is `word_out[3:0]` and the second nibble taken is `word_out[7:4]`.
- R3: Let edge p be the first clock edge at which `nib_stb` is sampled low after the second nibble was taken. Then `word_stb` is high for exactly the one clock that follows edge p+1.
- R4: `word_out` changes only at the edge where `word_stb` rises. It holds its value throughout the next byte's input phase.
- R5: A strobe held high for many cycles is captured once. Changes on `nib_in` while the strobe stays high have no effect.
- R6: A one-cycle strobe pulse is accepted. The nibble taken is the one present at the edge where the strobe is first seen high by a waiting state.
- R7: A strobe pulse seen only at edge p+1 or only at edge p+2 (during emission) is ignored. The next byte is built from the nibbles that follow it.
- R8: A strobe that rises during emission and is still high at edge p+3 is taken as the first nibble of the next byte, using the nibble present at edge p+3.
- R9: A reset after only the first nibble discards it. The next two nibbles form the next byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nib_in | input | 4 | Nibble from the sender |
| nib_stb | input | 1 | Sender strobe qualifying `nib_in` |
| word_out | output | 8 | Assembled byte |
| word_stb | output | 1 | One-clock pulse marking a new byte |

## Verification
Two things can fall in the same cycle:
- the emission of a finished byte, with `word_stb` high;
- the arrival of a fresh sender strobe.

The bench provokes this overlap by raising `nib_stb` one clock after the drop that ends a byte. It does so in three variants: a pulse seen only during `ST_EMIT`, a pulse seen only during `ST_EMIT_END`, and a strobe held across the whole emission. In each variant the bench judges the emitted byte and the width of its strobe. It also judges the contents of the following byte, which must leave out the intruding pulses and must start with the held strobe's nibble. All 256 nibble pairs are swept with strobe lengths of one to four cycles, and `nib_in` is scrambled while the strobe is held.

// File: rtl/nbb_pkg.sv
package nbb_pkg;

    // Controller states, binary encoded
    typedef enum logic [2:0] {
        ST_WAIT_LO  = 3'd0,
        ST_TAKE_LO  = 3'd1,
        ST_HOLD_LO  = 3'd2,
        ST_WAIT_HI  = 3'd3,
        ST_TAKE_HI  = 3'd4,
        ST_HOLD_HI  = 3'd5,
        ST_EMIT     = 3'd6,
        ST_EMIT_END = 3'd7
    } nbb_state_e;

    // Load enables from controller to datapath
    typedef struct packed {
        logic out_ld;
        logic hi_ld;
        logic lo_ld;
    } nbb_ctl_t;

endpackage

// File: rtl/nbb_ctrl.sv
module nbb_ctrl
    import nbb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     nib_stb,
    output nbb_ctl_t ctl
);

    nbb_state_e state_q;
    nbb_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT_LO;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic; each capture waits for the strobe to fall
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_LO:  if (nib_stb) state_d = ST_TAKE_LO;
            ST_TAKE_LO:  state_d = nib_stb ? ST_HOLD_LO : ST_WAIT_HI;
            ST_HOLD_LO:  if (!nib_stb) state_d = ST_WAIT_HI;
            ST_WAIT_HI:  if (nib_stb) state_d = ST_TAKE_HI;
            ST_TAKE_HI:  state_d = nib_stb ? ST_HOLD_HI : ST_EMIT;
            ST_HOLD_HI:  if (!nib_stb) state_d = ST_EMIT;
            ST_EMIT:     state_d = ST_EMIT_END;
            ST_EMIT_END: state_d = ST_WAIT_LO;
            default:     state_d = ST_WAIT_LO;
        endcase
    end

    // Moore outputs: load enables per state
    always_comb begin
        ctl = '0;
        unique case (state_q)
            ST_TAKE_LO: ctl.lo_ld  = 1'b1;
            ST_TAKE_HI: ctl.hi_ld  = 1'b1;
            ST_EMIT:    ctl.out_ld = 1'b1;
            default:    ctl = '0;
        endcase
    end

endmodule

// File: rtl/nbb_path.sv
module nbb_path
    import nbb_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NIB_W-1:0]     nib_in,
    input  nbb_ctl_t             ctl,
    output logic [2*NIB_W-1:0]   word_out,
    output logic                 word_stb
);

    localparam int HALVES = 2;
    localparam int WORD_W = HALVES * NIB_W;

    logic [NIB_W-1:0]  nib_q;
    logic [HALVES-1:0] half_ld;
    logic [WORD_W-1:0] joined;

    // Input sample: holds the nibble present when the strobe was seen
    always_ff @(posedge clk) begin
        if (rst) begin
            nib_q <= '0;
        end else begin
            nib_q <= nib_in;
        end
    end

    assign half_ld = {ctl.hi_ld, ctl.lo_ld};

    // One half register per nibble position; index 0 is the low half
    for (genvar g = 0; g < HALVES; g++) begin : g_half
        logic [NIB_W-1:0] half_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                half_q <= '0;
            end else if (half_ld[g]) begin
                half_q <= nib_q;
            end
        end
        assign joined[g*NIB_W +: NIB_W] = half_q;
    end

    // Output word and its strobe, registered together
    always_ff @(posedge clk) begin
        if (rst) begin
            word_out <= '0;
            word_stb <= 1'b0;
        end else begin
            word_stb <= ctl.out_ld;
            if (ctl.out_ld) begin
                word_out <= joined;
            end
        end
    end

endmodule

// File: rtl/nibble_pair_bridge.sv
module nibble_pair_bridge
    import nbb_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NIB_W-1:0]     nib_in,
    input  logic                 nib_stb,
    output logic [2*NIB_W-1:0]   word_out,
    output logic                 word_stb
);

    localparam int WORD_W = 2 * NIB_W;

    nbb_ctl_t ctl;

    nbb_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .nib_stb (nib_stb),
        .ctl     (ctl)
    );

    nbb_path #(
        .NIB_W (NIB_W)
    ) u_path (
        .clk      (clk),
        .rst      (rst),
        .nib_in   (nib_in),
        .ctl      (ctl),
        .word_out (word_out),
        .word_stb (word_stb)
    );

endmodule

// File: rtl/nbb_chk.sv
module nbb_chk #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              nib_stb,
    input logic [WORD_W-1:0] word_out,
    input logic              word_stb,
    input logic              lo_ld
);

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (word_out == '0 && !word_stb));                   // R1

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        word_stb |=> !word_stb);                                         // R3

    AST_STB_AFTER_DROP: assert property (@(posedge clk) disable iff (rst)
        $rose(word_stb) |-> !$past(nib_stb, 2));                         // R3

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!word_stb && !$past(rst)) |-> $stable(word_out));               // R4

    AST_LO_AFTER_STB: assert property (@(posedge clk) disable iff (rst)
        lo_ld |-> $past(nib_stb));                                       // R6

endmodule

bind nibble_pair_bridge nbb_chk #(
    .WORD_W (WORD_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .nib_stb  (nib_stb),
    .word_out (word_out),
    .word_stb (word_stb),
    .lo_ld    (ctl.lo_ld)
);

// File: tb/tb_nibble_pair_bridge.sv
module tb_nibble_pair_bridge;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] nib_in = 4'h0;
    logic       nib_stb = 1'b0;
    logic [7:0] word_out;
    logic       word_stb;
    logic [7:0] last_word = 8'h00;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nibble_pair_bridge #(.NIB_W(4)) dut (
        .clk      (clk),
        .rst      (rst),
        .nib_in   (nib_in),
        .nib_stb  (nib_stb),
        .word_out (word_out),
        .word_stb (word_stb)
    );

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wrap_up;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    endtask

    // Strobe of n cycles; nib_in scrambled after the first cycle (R5)
    task automatic pulse(input logic [3:0] v, input int n);
        @(negedge clk);
        nib_in  = v;
        nib_stb = 1'b1;
        for (int c = 1; c < n; c++) begin
            @(negedge clk);
            nib_in = v ^ 4'(c);
        end
        @(negedge clk);
        nib_stb = 1'b0;
        nib_in  = ~v;
    endtask

    // Called right after the strobe was driven low (before edge p)
    task automatic expect_byte(input logic [3:0] lo, input logic [3:0] hi);
        @(negedge clk);
        chk(word_stb == 1'b0, "R3 strobe early", {7'd0, word_stb}, 8'd0);
        @(negedge clk);
        chk(word_stb == 1'b1, "R3 strobe missing", {7'd0, word_stb}, 8'd1);
        chk(word_out == {hi, lo}, "R2 byte layout", word_out, {hi, lo});
        @(negedge clk);
        chk(word_stb == 1'b0, "R3 strobe width", {7'd0, word_stb}, 8'd0);
        chk(word_out == {hi, lo}, "R4 byte held", word_out, {hi, lo});
        last_word = {hi, lo};
    endtask

    task automatic send_byte(input logic [3:0] lo, input logic [3:0] hi, input int nlo, input int nhi);
        pulse(lo, nlo);
        chk(word_out == last_word, "R4 hold during input", word_out, last_word);
        pulse(hi, nhi);
        expect_byte(lo, hi);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R1..: actual timeout expected completion");
        wrap_up();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(word_out == 8'h00, "R1 reset word", word_out, 8'h00);
        chk(word_stb == 1'b0, "R1 reset strobe", {7'd0, word_stb}, 8'd0);
        rst = 1'b0;

        // R2 R3 R4 R5 R6: all nibble pairs, strobe lengths 1..4
        for (int i = 0; i < 256; i++) begin
            send_byte(4'(i), 4'(i >> 4), 1 + (i % 4), 1 + ((i >> 2) % 3));
        end

        // R5: very long strobes with a changing nibble
        send_byte(4'h6, 4'hB, 20, 17);

        // R7: pulse seen only in the emit cycle (edge p+1)
        pulse(4'h1, 1);
        pulse(4'hE, 2);
        @(negedge clk);
        nib_stb = 1'b1;
        nib_in  = 4'hF;
        @(negedge clk);
        chk(word_out == 8'hE1, "R7 emit byte", word_out, 8'hE1);
        chk(word_stb == 1'b1, "R7 emit strobe", {7'd0, word_stb}, 8'd1);
        nib_stb = 1'b0;
        @(negedge clk);
        chk(word_stb == 1'b0, "R7 strobe width", {7'd0, word_stb}, 8'd0);
        last_word = 8'hE1;
        send_byte(4'h3, 4'hC, 1, 1);

        // R7: pulse seen only at edge p+2
        pulse(4'h4, 1);
        pulse(4'h8, 1);
        @(negedge clk);
        @(negedge clk);
        chk(word_out == 8'h84, "R7 emit byte", word_out, 8'h84);
        nib_stb = 1'b1;
        nib_in  = 4'hD;
        @(negedge clk);
        nib_stb = 1'b0;
        last_word = 8'h84;
        send_byte(4'h0, 4'h7, 2, 1);

        // R8: strobe held across emission becomes the next low nibble
        pulse(4'h2, 1);
        pulse(4'h9, 1);
        @(negedge clk);
        nib_stb = 1'b1;
        nib_in  = 4'hA;
        @(negedge clk);
        chk(word_out == 8'h92, "R8 emit byte", word_out, 8'h92);
        chk(word_stb == 1'b1, "R8 emit strobe", {7'd0, word_stb}, 8'd1);
        @(negedge clk);
        chk(word_stb == 1'b0, "R8 strobe width", {7'd0, word_stb}, 8'd0);
        @(negedge clk);
        nib_stb = 1'b0;
        last_word = 8'h92;
        pulse(4'h5, 1);
        expect_byte(4'hA, 4'h5);

        // R9: reset after a lone first nibble
        pulse(4'h7, 2);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(word_out == 8'h00, "R9 reset clears word", word_out, 8'h00);
        chk(word_stb == 1'b0, "R9 reset clears strobe", {7'd0, word_stb}, 8'd0);
        rst = 1'b0;
        last_word = 8'h00;
        send_byte(4'h2, 4'h9, 1, 3);

        wrap_up();
    end

endmodule